// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limit Controller

This block sits between a PWM command and the enable of a low-side gate driver. Each clock it takes a digitized current-sense sample and compares it against an effective limit threshold. When the sensed current comes within a fixed offset of that threshold, the block ends the drive pulse in the next clock. It then raises a limit flag for the host. The flag and the output inhibit stay latched until the PWM command shows a new rising edge, so the limit acts once per switching period.

The limit threshold comes from a digitized request code together with a bit that says whether the request pin is connected. A missing request falls back to a default level. A connected request is held inside a bounded window. Two supply readings are also monitored, the main supply and the logic rail, each through its own hysteresis comparator. While either supply is not good, the drive is held low and the flag is held high. The flag then drops once both supplies are good, which tells the host that power pulses may start.

All analog quantities are integer codes in millivolts. The default parameters follow the levels given in the requirements below.

Top module: `cbc_limiter`

## Requirements
- R1: While the synchronous reset is high, and on the first cycles after it, `drive_out` is 0 and `limit_flag` is 1.
- R2: A current sample trips the limiter when `sense_code + 25 > threshold`. This trip forces `drive_out` to 0 and `limit_flag` to 1 at the second rising clock edge after the sample is presented.
- R3: After a trip, `drive_out` stays 0 and `limit_flag` stays 1 until a synchronized rising edge of `pwm_in` arrives while no trip is present. That edge clears both, and `drive_out` then follows `pwm_in` again.
- R4: A trip in the same cycle as the synchronized PWM rising edge wins over the clear: the latch stays set.
- R5: With supplies good and no latched trip, `drive_out` equals `pwm_in` delayed by three rising clock edges, through a two-flop synchronizer and the output register.
- R6: A connected threshold request above 1000 is limited to 1000.
- R7: A connected threshold request below 250 is raised to 250. A parameter can set this floor to 0, which removes it.
- R8: When `lim_valid` is 0, the threshold is 500 whatever `lim_code` holds.
- R9: The main supply turns good when `vmain_code >= 4500` and turns bad when `vmain_code < 4250`. Between those two levels it keeps its previous state. While it is bad, `drive_out` is 0 and `limit_flag` is 1.
- R10: The logic rail turns good when `vrail_code >= 3000` and turns bad when `vrail_code < 2800`, with the same hold in between. A bad rail has the same effect as in R9.
- R11: At start-up, `limit_flag` stays 1 until both supplies are good. It then falls to 0 at the second edge after the second supply crosses its turn-on level, as long as no trip is present.
- R12: With the floor removed, a threshold below 25 trips on a zero current sample. The flag stays latched through PWM pulses for as long as that threshold is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command, asynchronous to clk |
| sense_code | input | CS_W | Current-sense sample, mV |
| lim_code | input | CS_W | Requested limit threshold, mV |
| lim_valid | input | 1 | 1 when the threshold request is connected |
| vmain_code | input | SUP_W | Main supply reading, mV |
| vrail_code | input | SUP_W | Logic rail reading, mV |
| drive_out | output | 1 | Gated drive enable |
| limit_flag | output | 1 | Latched current-limit / not-ready flag |

## Verification
Each result has a fixed delay. A change on `pwm_in` reaches `drive_out` at the third rising edge, because it passes two synchronizer flops and the output register. A change on the sense, threshold or supply inputs reaches both outputs at the second edge: one input register, then the output register. The bench changes inputs one time unit after a rising edge and compares the outputs at the falling edge. It does this against a cycle model that carries those same delays, and the directed corner cases sample in exactly the cycle named above.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Supply health as seen by the gating logic.
  typedef struct packed {
    logic main_ok;
    logic rail_ok;
  } sup_state_t;

  // Every supply flag must be set before pulses are allowed.
  function automatic logic sup_good(sup_state_t s);
    return s.main_ok & s.rail_ok;
  endfunction

endpackage

// File: rtl/cbc_sync.sv
module cbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic level,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      prev_q <= 1'b0;
    end else begin
      chain  <= {chain[LAST-1:0], d};
      prev_q <= chain[LAST];
    end
  end

  assign level = chain[LAST];
  assign rise  = chain[LAST] & ~prev_q;
endmodule

// File: rtl/cbc_hyst.sv
module cbc_hyst #(
  parameter int W      = 13,
  parameter int ON_LVL = 4500,
  parameter int OFF_LVL = 4250
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic         ok
);
  localparam logic [W-1:0] ON_C  = W'(ON_LVL);
  localparam logic [W-1:0] OFF_C = W'(OFF_LVL);

  logic ok_d;

  always_comb begin
    if (ok) ok_d = (level >= OFF_C);
    else    ok_d = (level >= ON_C);
  end

  always_ff @(posedge clk) begin
    if (rst) ok <= 1'b0;
    else     ok <= ok_d;
  end
endmodule

// File: rtl/cbc_thresh.sv
module cbc_thresh #(
  parameter int CS_W    = 11,
  parameter int OFFSET  = 25,
  parameter int LIM_MIN = 250,
  parameter int LIM_MAX = 1000,
  parameter int LIM_DEF = 500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CS_W-1:0] sense_code,
  input  logic [CS_W-1:0] lim_code,
  input  logic            lim_valid,
  output logic [CS_W-1:0] thr_q,
  output logic            trip
);
  localparam int CW = CS_W + 1;
  localparam logic [CS_W-1:0] MAX_C = CS_W'(LIM_MAX);
  localparam logic [CS_W-1:0] DEF_C = CS_W'(LIM_DEF);
  localparam logic [CW-1:0]   OFF_C = CW'(OFFSET);

  logic [CS_W-1:0] cs_q;
  logic [CS_W-1:0] top_lim;
  logic [CS_W-1:0] thr_d;

  assign top_lim = (lim_code > MAX_C) ? MAX_C : lim_code;

  generate
    if (LIM_MIN > 0) begin : g_floor
      localparam logic [CS_W-1:0] MIN_C = CS_W'(LIM_MIN);
      always_comb begin
        if (!lim_valid)         thr_d = DEF_C;
        else if (top_lim < MIN_C) thr_d = MIN_C;
        else                    thr_d = top_lim;
      end
    end else begin : g_nofloor
      always_comb begin
        if (!lim_valid) thr_d = DEF_C;
        else            thr_d = top_lim;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= '0;
      thr_q <= DEF_C;
    end else begin
      cs_q  <= sense_code;
      thr_q <= thr_d;
    end
  end

  // Offset added on the sense side keeps the compare unsigned when thr < OFFSET.
  assign trip = ({1'b0, cs_q} + OFF_C) > {1'b0, thr_q};
endmodule

// File: rtl/cbc_limiter.sv
module cbc_limiter
  import cbc_pkg::*;
#(
  parameter int CS_W     = 11,
  parameter int SUP_W    = 13,
  parameter int OFFSET   = 25,
  parameter int LIM_MIN  = 250,
  parameter int LIM_MAX  = 1000,
  parameter int LIM_DEF  = 500,
  parameter int MAIN_ON  = 4500,
  parameter int MAIN_OFF = 4250,
  parameter int RAIL_ON  = 3000,
  parameter int RAIL_OFF = 2800,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_in,
  input  logic [CS_W-1:0]  sense_code,
  input  logic [CS_W-1:0]  lim_code,
  input  logic             lim_valid,
  input  logic [SUP_W-1:0] vmain_code,
  input  logic [SUP_W-1:0] vrail_code,
  output logic             drive_out,
  output logic             limit_flag
);
  logic            pwm_s;
  logic            rise;
  logic [CS_W-1:0] thr_q;
  logic            trip;
  sup_state_t      sup;
  logic            pg;
  logic            lat_q;
  logic            lat_n;
  logic            drive_q;
  logic            flag_q;

  cbc_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(pwm_in), .level(pwm_s), .rise(rise)
  );

  cbc_thresh #(
    .CS_W(CS_W), .OFFSET(OFFSET), .LIM_MIN(LIM_MIN),
    .LIM_MAX(LIM_MAX), .LIM_DEF(LIM_DEF)
  ) u_thr (
    .clk(clk), .rst(rst), .sense_code(sense_code), .lim_code(lim_code),
    .lim_valid(lim_valid), .thr_q(thr_q), .trip(trip)
  );

  cbc_hyst #(.W(SUP_W), .ON_LVL(MAIN_ON), .OFF_LVL(MAIN_OFF)) u_main (
    .clk(clk), .rst(rst), .level(vmain_code), .ok(sup.main_ok)
  );

  cbc_hyst #(.W(SUP_W), .ON_LVL(RAIL_ON), .OFF_LVL(RAIL_OFF)) u_rail (
    .clk(clk), .rst(rst), .level(vrail_code), .ok(sup.rail_ok)
  );

  assign pg = sup_good(sup);

  // Latch: set by a trip, kept until a clean PWM rising edge; a trip wins.
  assign lat_n = pg & (trip | (lat_q & ~rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q   <= 1'b0;
      drive_q <= 1'b0;
      flag_q  <= 1'b1;
    end else begin
      lat_q   <= lat_n;
      drive_q <= pg & pwm_s & ~lat_n;
      flag_q  <= ~pg | lat_n;
    end
  end

  assign drive_out  = drive_q;
  assign limit_flag = flag_q;
endmodule

// File: rtl/cbc_limiter_chk.sv
module cbc_limiter_chk #(
  parameter int CS_W    = 11,
  parameter int LIM_MIN = 250,
  parameter int LIM_MAX = 1000
) (
  input logic            clk,
  input logic            rst,
  input logic            pwm_in,
  input logic            pg,
  input logic            trip,
  input logic            rise,
  input logic            lat_q,
  input logic            drive_q,
  input logic            flag_q,
  input logic [CS_W-1:0] thr_q
);
  assert_trip_kills_R2: assert property (@(posedge clk) disable iff (rst)
    trip |=> (!drive_q && flag_q));

  assert_hold_latch_R3: assert property (@(posedge clk) disable iff (rst)
    (lat_q && !rise) |=> !drive_q);

  assert_trip_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (pg && trip && rise) |=> flag_q);

  assert_drive_needs_pwm_R5: assert property (@(posedge clk) disable iff (rst)
    drive_q |-> $past(pwm_in, 3));

  assert_thr_window_R6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, thr_q} <= (CS_W+1)'(LIM_MAX)) && ({1'b0, thr_q} >= (CS_W+1)'(LIM_MIN)));

  assert_lockout_R9: assert property (@(posedge clk) disable iff (rst)
    !pg |=> (!drive_q && flag_q));

  assert_ready_after_good_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(pg));
endmodule

bind cbc_limiter cbc_limiter_chk #(
  .CS_W(CS_W), .LIM_MIN(LIM_MIN), .LIM_MAX(LIM_MAX)
) u_chk (
  .clk(clk), .rst(rst), .pwm_in(pwm_in), .pg(pg), .trip(trip), .rise(rise),
  .lat_q(lat_q), .drive_q(drive_q), .flag_q(flag_q), .thr_q(thr_q)
);

// File: tb/tb_cbc_limiter.sv
module tb_cbc_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int CS_W = 11;
  localparam int SUP_W = 13;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_in = 1'b0;
  logic [CS_W-1:0] sense_code = '0;
  logic [CS_W-1:0] lim_code = '0;
  logic lim_valid = 1'b0;
  logic [SUP_W-1:0] vmain_code = '0;
  logic [SUP_W-1:0] vrail_code = '0;
  logic drive_out, limit_flag;

  logic lo_pwm = 1'b0;
  logic lo_drive, lo_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit auto_chk = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  cbc_limiter dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .sense_code(sense_code),
    .lim_code(lim_code), .lim_valid(lim_valid), .vmain_code(vmain_code),
    .vrail_code(vrail_code), .drive_out(drive_out), .limit_flag(limit_flag)
  );

  cbc_limiter #(.LIM_MIN(0)) dut_lo (
    .clk(clk), .rst(rst), .pwm_in(lo_pwm), .sense_code(11'd0),
    .lim_code(11'd10), .lim_valid(1'b1), .vmain_code(vmain_code),
    .vrail_code(vrail_code), .drive_out(lo_drive), .limit_flag(lo_flag)
  );

  // ---------------- requirement-level reference ----------------
  function automatic int eff_thr(int lim, bit valid);
    if (!valid) return 500;
    if (lim > 1000) return 1000;
    if (lim < 250) return 250;
    return lim;
  endfunction

  function automatic bit over(int cs, int thr);
    return (cs + 25) > thr;
  endfunction

  function automatic bit hyst(bit prev, int v, int on_l, int off_l);
    return prev ? (v >= off_l) : (v >= on_l);
  endfunction

  bit m_p1, m_p2, m_p3, m_mok, m_rok, m_lat, m_drv, m_flag;
  int m_cs, m_thr;

  always @(posedge clk) begin
    bit pg, tr, rs, ln;
    if (rst) begin
      m_p1 <= 0; m_p2 <= 0; m_p3 <= 0; m_mok <= 0; m_rok <= 0;
      m_lat <= 0; m_drv <= 0; m_flag <= 1; m_cs <= 0; m_thr <= 500;
    end else begin
      pg = m_mok & m_rok;
      tr = over(m_cs, m_thr);
      rs = m_p2 & ~m_p3;
      ln = pg & (tr | (m_lat & ~rs));
      m_p1 <= pwm_in; m_p2 <= m_p1; m_p3 <= m_p2;
      m_cs <= int'(sense_code);
      m_thr <= eff_thr(int'(lim_code), lim_valid);
      m_mok <= hyst(m_mok, int'(vmain_code), 4500, 4250);
      m_rok <= hyst(m_rok, int'(vrail_code), 3000, 2800);
      m_lat <= ln;
      m_drv <= pg & m_p2 & ~ln;
      m_flag <= ~pg | ln;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (auto_chk && !rst && !finished) begin
      check(cur_tag, "drive_out", drive_out, m_drv);
      check(cur_tag, "limit_flag", limit_flag, m_flag);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    step(3);
    at_neg();
    check("R1", "drive in reset", drive_out, 0);
    check("R1", "flag in reset", limit_flag, 1);
    step(1);
    rst = 1'b0;
    step(2);
    at_neg();
    check("R1", "drive after reset", drive_out, 0);
    check("R1", "flag after reset", limit_flag, 1);
    auto_chk = 1'b1;

    // R11: handshake, rail good first, main later
    cur_tag = "R11";
    lim_valid = 1'b1; lim_code = 11'd600;
    vrail_code = 13'd3300;
    step(4);
    at_neg();
    check("R11", "flag while main low", limit_flag, 1);
    step(1);
    vmain_code = 13'd5000;
    step(1);
    at_neg();
    check("R11", "flag one edge after good", limit_flag, 1);
    step(1);
    at_neg();
    check("R11", "flag two edges after good", limit_flag, 0);
    step(1);

    // R5: drive follows PWM with three-edge delay
    cur_tag = "R5";
    pwm_in = 1'b1;
    step(2);
    at_neg();
    check("R5", "drive before 3rd edge", drive_out, 0);
    step(1);
    at_neg();
    check("R5", "drive at 3rd edge", drive_out, 1);
    step(1);
    pwm_in = 1'b0;
    step(3);
    at_neg();
    check("R5", "drive low after pwm low", drive_out, 0);
    pwm_in = 1'b1;
    step(5);

    // R2: trip ends pulse at second edge
    cur_tag = "R2";
    sense_code = 11'd580;          // 605 > 600
    step(1);
    at_neg();
    check("R2", "drive one edge after sample", drive_out, 1);
    step(1);
    at_neg();
    check("R2", "drive two edges after sample", drive_out, 0);
    check("R2", "flag two edges after sample", limit_flag, 1);
    step(1);

    // R3: latch holds until a clean rising edge
    cur_tag = "R3";
    sense_code = 11'd0;
    step(6);
    at_neg();
    check("R3", "drive held low", drive_out, 0);
    check("R3", "flag held", limit_flag, 1);
    step(1);
    pwm_in = 1'b0;
    step(4);
    pwm_in = 1'b1;
    step(3);
    at_neg();
    check("R3", "drive restored", drive_out, 1);
    check("R3", "flag cleared", limit_flag, 0);
    step(1);

    // R4: trip coincident with the synchronized rising edge
    cur_tag = "R4";
    sense_code = 11'd700;
    step(3);
    pwm_in = 1'b0;
    step(4);
    pwm_in = 1'b1;                 // rise seen after two edges, trip still there
    step(4);
    at_neg();
    check("R4", "flag kept on edge with trip", limit_flag, 1);
    check("R4", "drive kept low", drive_out, 0);
    step(1);
    sense_code = 11'd0;
    pwm_in = 1'b0;
    step(4);
    pwm_in = 1'b1;
    step(5);

    // R6: upper clamp
    cur_tag = "R6";
    lim_code = 11'd2000;
    sense_code = 11'd970;          // 995, no trip
    step(3);
    at_neg();
    check("R6", "no trip below clamp", limit_flag, 0);
    step(1);
    sense_code = 11'd980;          // 1005 > 1000
    step(2);
    at_neg();
    check("R6", "trip at clamp", limit_flag, 1);
    step(1);
    sense_code = 11'd0; pwm_in = 1'b0; step(4); pwm_in = 1'b1; step(5);

    // R7: lower floor
    cur_tag = "R7";
    lim_code = 11'd10;
    sense_code = 11'd200;          // 225 < 250
    step(3);
    at_neg();
    check("R7", "no trip above floor", limit_flag, 0);
    step(1);
    sense_code = 11'd230;          // 255 > 250
    step(2);
    at_neg();
    check("R7", "trip at floor", limit_flag, 1);
    step(1);
    sense_code = 11'd0; pwm_in = 1'b0; step(4); pwm_in = 1'b1; step(5);

    // R8: default threshold when not connected
    cur_tag = "R8";
    lim_valid = 1'b0; lim_code = 11'd1500;
    sense_code = 11'd470;          // 495
    step(3);
    at_neg();
    check("R8", "no trip under default", limit_flag, 0);
    step(1);
    sense_code = 11'd480;          // 505 > 500
    step(2);
    at_neg();
    check("R8", "trip over default", limit_flag, 1);
    step(1);
    sense_code = 11'd0; pwm_in = 1'b0; step(4); pwm_in = 1'b1; step(5);
    lim_valid = 1'b1; lim_code = 11'd800;

    // R9: main supply hysteresis
    cur_tag = "R9";
    vmain_code = 13'd4300;
    step(3);
    at_neg();
    check("R9", "still good in band", drive_out, 1);
    step(1);
    vmain_code = 13'd4249;
    step(2);
    at_neg();
    check("R9", "drive off when bad", drive_out, 0);
    check("R9", "flag on when bad", limit_flag, 1);
    step(1);
    vmain_code = 13'd4499;
    step(3);
    at_neg();
    check("R9", "still bad in band", limit_flag, 1);
    step(1);
    vmain_code = 13'd4500;
    step(5);

    // R10: rail hysteresis
    cur_tag = "R10";
    vrail_code = 13'd2850;
    step(3);
    at_neg();
    check("R10", "rail good in band", limit_flag, 0);
    step(1);
    vrail_code = 13'd2799;
    step(2);
    at_neg();
    check("R10", "rail bad flag", limit_flag, 1);
    step(1);
    vrail_code = 13'd2999;
    step(3);
    at_neg();
    check("R10", "rail still bad in band", limit_flag, 1);
    step(1);
    vrail_code = 13'd3000;
    step(3);

    // R12: floor removed, tiny threshold trips at zero current
    lo_pwm = 1'b1;
    step(4);
    lo_pwm = 1'b0;
    step(4);
    lo_pwm = 1'b1;
    step(4);
    at_neg();
    check("R12", "flag latched at zero sense", lo_flag, 1);
    check("R12", "drive held low", lo_drive, 0);
    step(1);

    // Random mix, checked cycle by cycle against the reference
    cur_tag = "R2";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 15) pwm_in = ~pwm_in;
      if (r >= 15 && r < 30) sense_code = 11'($urandom_range(0, 1100));
      if (r >= 30 && r < 35) begin
        lim_code = 11'($urandom_range(0, 2047));
        lim_valid = ($urandom_range(0, 3) != 0);
      end
      if (r == 40) vmain_code = 13'($urandom_range(4100, 4700));
      if (r == 41) vrail_code = 13'($urandom_range(2700, 3100));
      if (r == 42) begin vmain_code = 13'd5000; vrail_code = 13'd3300; end
      step(1);
    end
    step(2);
    auto_chk = 1'b0;
    finish_run();
  end
endmodule